// File: doc/BRIEF.md
# SPI Register-Access Host with Ready Polling

This block is the host side of a framed register-access exchange over SPI. A local agent hands it one command (read or write, a 24-bit register address and a payload length from 1 to 64 bytes). The engine then drops chip select and clocks a four-byte header. It watches the least significant bit of the last byte the target returned during that header. While that bit reads 0 it keeps clocking filler bytes, one at a time, and tests the same bit of each new byte. Once the bit reads 1 it moves the whole payload without pausing.

Write payload is fetched from a local buffer that the engine addresses with a byte index. Read payload is handed back one byte per strobe. A programmable limit on the number of filler bytes ends a transfer whose target never becomes ready. In that case the engine releases chip select and reports an error together with the completion pulse. The serial clock runs in mode 0 (idle low, sampled on the rising edge), and a configuration input sets the length of each half period.

Top module: `spi_regx_host`

## Requirements
- R1: The header is four bytes sent MSB first: a command byte {read, 1'b0, length-1 in bits 5:0} (bit 7 is 1 for a read), then address bits 23:16, 15:8 and 7:0.
- R2: The serial clock idles low. Each high and each low phase inside a byte lasts cfg_half_div+1 clock cycles. MOSI changes only while the serial clock is low, and MISO is sampled on its rising edge.
- R3: If bit 0 of the fourth byte received during the header is 1, the first payload byte is clocked as the fifth byte, and the frame is 4+length bytes.
- R4: If that bit is 0, the engine clocks filler bytes of value 0x00 and tests bit 0 of each one. It stops at the first byte whose bit 0 is 1. With N filler bytes the frame is 4+N+length bytes.
- R5: After the ready bit has been seen, payload bytes whose bit 0 is 0 do not cause further polling or lengthen the frame.
- R6: For a write, payload byte k is the wr_data value present while wr_idx equals k, sent in index order starting at 0.
- R7: For a read, MOSI carries 0x00 during the payload. rd_valid pulses once for each payload byte, in order, and rd_data holds the byte received.
- R8: Chip select stays low from before the first header bit until after the last bit of the frame. It then stays high for at least 2*(cfg_half_div+1) cycles before done pulses. The serial clock stays low while chip select is high.
- R9: If cfg_poll_max filler bytes all return bit 0 equal to 0, the transfer aborts: no payload is moved, chip select rises, and err is high in the done cycle. With cfg_poll_max of 0, a not-ready header ends in the error at once.
- R10: cmd_ready is high only while the engine is idle, and a cmd_valid raised during a transfer has no effect.
- R11: After reset, chip select is high, the serial clock is low, cmd_ready is high, and done, err and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half_div | input | DIV_W | Serial clock half period minus one, in clock cycles |
| cfg_poll_max | input | POLL_W | Most filler bytes allowed before the transfer aborts |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command accepted on valid |
| cmd_read | input | 1 | 1 for read, 0 for write |
| cmd_addr | input | 24 | Register address |
| cmd_len | input | 7 | Payload length, 1 to 64 |
| wr_idx | output | 6 | Index of the next write byte wanted from the buffer |
| wr_data | input | 8 | Buffer byte at wr_idx |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | High with done when the poll limit was hit |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Host-to-target data |
| spi_miso | input | 1 | Target-to-host data |

## Verification
A behavioural target answers each frame from a random byte script, so the header filler bits hold random values, and it varies the number of not-ready bytes from none up to one more than the poll limit. A zero-wait transfer separates a host that trusts the header answer from one that always polls once. The exact-limit and limit-plus-one cases separate an off-by-one in the abort test from a correct one. Read payloads with alternating low bits show whether polling wrongly continues after ready. Lengths of 1 and 64, clock dividers of 0 to 3, and a command raised mid-transfer round out the directed cases.

// File: rtl/spi_regx_pkg.sv
package spi_regx_pkg;

    localparam int unsigned MAX_PAYLOAD = 64;
    localparam int unsigned IDX_W       = $clog2(MAX_PAYLOAD);
    localparam int unsigned LEN_W       = IDX_W + 1;
    localparam int unsigned ADDR_W      = 24;
    localparam int unsigned HDR_LAST    = 3;

    localparam logic [7:0] POLL_FILL = 8'h00;
    localparam logic [7:0] READ_FILL = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_POLL,
        ST_DATA,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  len_m1;
    } xfer_cmd_t;

    function automatic logic [7:0] header_byte(input xfer_cmd_t c, input logic [1:0] i);
        logic [7:0] b;
        case (i)
            2'd0:    b = {c.rd, 1'b0, c.len_m1};
            2'd1:    b = c.addr[23:16];
            2'd2:    b = c.addr[15:8];
            default: b = c.addr[7:0];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/spi_regx_clkdiv.sv
module spi_regx_clkdiv #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == half_div);

    always_ff @(posedge clk) begin
        if (rst || !en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_regx_byte_shift.sv
module spi_regx_byte_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);
    logic [7:0] sh_tx;
    logic [7:0] sh_rx;
    logic [2:0] bitc;

    assign mosi    = sh_tx[7];
    assign rx_byte = sh_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_tx <= '0;
            sh_rx <= '0;
            bitc  <= '0;
            busy  <= 1'b0;
            sclk  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sh_tx <= tx_byte;
                bitc  <= '0;
                busy  <= 1'b1;
                sclk  <= 1'b0;
            end else if (busy && tick) begin
                if (!sclk) begin
                    sclk  <= 1'b1;
                    sh_rx <= {sh_rx[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bitc == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        sh_tx <= {sh_tx[6:0], 1'b0};
                        bitc  <= bitc + 3'd1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_regx_seq.sv
module spi_regx_seq
    import spi_regx_pkg::*;
#(
    parameter int unsigned POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [POLL_W-1:0] cfg_poll_max,
    input  logic              cmd_valid,
    input  xfer_cmd_t         cmd_in,
    output logic              cmd_ready,
    output logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    output logic              byte_start,
    output logic [7:0]        byte_tx,
    input  logic              byte_done,
    input  logic [7:0]        byte_rx,
    output logic              gap_en,
    input  logic              tick,
    output logic              cs_n,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic              err
);
    seq_state_e        state;
    xfer_cmd_t         cmd_q;
    logic [1:0]        hdr_idx;
    logic [LEN_W-1:0]  pl_idx;
    logic [POLL_W-1:0] poll_cnt;
    logic              err_flag;
    logic              gap_half;
    logic [7:0]        pay_byte;
    logic [LEN_W-1:0]  len_total;

    assign cmd_ready = (state == ST_IDLE);
    assign gap_en    = (state == ST_GAP);
    assign wr_idx    = pl_idx[IDX_W-1:0];
    assign pay_byte  = cmd_q.rd ? READ_FILL : wr_data;
    assign len_total = LEN_W'(cmd_q.len_m1) + LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cmd_q      <= '0;
            hdr_idx    <= '0;
            pl_idx     <= '0;
            poll_cnt   <= '0;
            err_flag   <= 1'b0;
            gap_half   <= 1'b0;
            cs_n       <= 1'b1;
            byte_start <= 1'b0;
            byte_tx    <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            byte_start <= 1'b0;
            rd_valid   <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        cmd_q      <= cmd_in;
                        cs_n       <= 1'b0;
                        hdr_idx    <= '0;
                        pl_idx     <= '0;
                        err_flag   <= 1'b0;
                        byte_start <= 1'b1;
                        byte_tx    <= header_byte(cmd_in, 2'd0);
                        state      <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (byte_done) begin
                        if (hdr_idx != 2'(HDR_LAST)) begin
                            hdr_idx    <= hdr_idx + 2'd1;
                            byte_start <= 1'b1;
                            byte_tx    <= header_byte(cmd_q, hdr_idx + 2'd1);
                        end else if (byte_rx[0]) begin
                            byte_start <= 1'b1;
                            byte_tx    <= pay_byte;
                            pl_idx     <= pl_idx + 1'b1;
                            state      <= ST_DATA;
                        end else if (cfg_poll_max == '0) begin
                            cs_n     <= 1'b1;
                            err_flag <= 1'b1;
                            gap_half <= 1'b0;
                            state    <= ST_GAP;
                        end else begin
                            poll_cnt   <= POLL_W'(1);
                            byte_start <= 1'b1;
                            byte_tx    <= POLL_FILL;
                            state      <= ST_POLL;
                        end
                    end
                end
                ST_POLL: begin
                    if (byte_done) begin
                        if (byte_rx[0]) begin
                            byte_start <= 1'b1;
                            byte_tx    <= pay_byte;
                            pl_idx     <= pl_idx + 1'b1;
                            state      <= ST_DATA;
                        end else if (poll_cnt >= cfg_poll_max) begin
                            cs_n     <= 1'b1;
                            err_flag <= 1'b1;
                            gap_half <= 1'b0;
                            state    <= ST_GAP;
                        end else begin
                            poll_cnt   <= poll_cnt + 1'b1;
                            byte_start <= 1'b1;
                            byte_tx    <= POLL_FILL;
                        end
                    end
                end
                ST_DATA: begin
                    if (byte_done) begin
                        if (cmd_q.rd) begin
                            rd_valid <= 1'b1;
                            rd_data  <= byte_rx;
                        end
                        if (pl_idx == len_total) begin
                            cs_n     <= 1'b1;
                            gap_half <= 1'b0;
                            state    <= ST_GAP;
                        end else begin
                            byte_start <= 1'b1;
                            byte_tx    <= pay_byte;
                            pl_idx     <= pl_idx + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            done  <= 1'b1;
                            err   <= err_flag;
                            state <= ST_IDLE;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_regx_host.sv
module spi_regx_host
    import spi_regx_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic [POLL_W-1:0] cfg_poll_max,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic              err,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    xfer_cmd_t  cmd_in;
    logic       byte_start;
    logic [7:0] byte_tx;
    logic       byte_done;
    logic [7:0] byte_rx;
    logic       byte_busy;
    logic       gap_en;
    logic       tick;

    always_comb begin
        cmd_in.rd     = cmd_read;
        cmd_in.addr   = cmd_addr;
        cmd_in.len_m1 = IDX_W'(cmd_len - LEN_W'(1));
    end

    spi_regx_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .en       (byte_busy | gap_en),
        .half_div (cfg_half_div),
        .tick     (tick)
    );

    spi_regx_byte_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (byte_start),
        .tx_byte (byte_tx),
        .tick    (tick),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .busy    (byte_busy),
        .done    (byte_done),
        .rx_byte (byte_rx)
    );

    spi_regx_seq #(.POLL_W(POLL_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cfg_poll_max (cfg_poll_max),
        .cmd_valid    (cmd_valid),
        .cmd_in       (cmd_in),
        .cmd_ready    (cmd_ready),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .byte_start   (byte_start),
        .byte_tx      (byte_tx),
        .byte_done    (byte_done),
        .byte_rx      (byte_rx),
        .gap_en       (gap_en),
        .tick         (tick),
        .cs_n         (spi_cs_n),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .done         (done),
        .err          (err)
    );
endmodule

// File: rtl/spi_regx_host_chk.sv
module spi_regx_host_chk
    import spi_regx_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned POLL_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [DIV_W-1:0]  cfg_half_div,
    input logic [POLL_W-1:0] cfg_poll_max,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_read,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [LEN_W-1:0]  cmd_len,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [7:0]        wr_data,
    input logic              rd_valid,
    input logic [7:0]        rd_data,
    input logic              done,
    input logic              err,
    input logic              spi_sclk,
    input logic              spi_cs_n,
    input logic              spi_mosi,
    input logic              spi_miso
);
    assert_sclk_low_when_deselected_R8: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    assert_hold_after_release_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |=> !done);

    assert_mosi_steady_while_high_R2: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    assert_err_only_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    assert_ready_only_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> spi_cs_n);

    assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> (cmd_ready && !done));

    assert_read_inside_frame_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!spi_cs_n));
endmodule

bind spi_regx_host spi_regx_host_chk #(.DIV_W(DIV_W), .POLL_W(POLL_W)) i_chk (.*);

// File: tb/test_spi_regx_host.sv
module test_spi_regx_host;
    localparam int DIV_W  = 8;
    localparam int POLL_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DIV_W-1:0]  cfg_half_div = '0;
    logic [POLL_W-1:0] cfg_poll_max = '0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic              cmd_read = 1'b0;
    logic [23:0]       cmd_addr = '0;
    logic [6:0]        cmd_len = 7'd1;
    logic [5:0]        wr_idx;
    logic [7:0]        wr_data;
    logic              rd_valid;
    logic [7:0]        rd_data;
    logic              done;
    logic              err;
    logic              spi_sclk;
    logic              spi_cs_n;
    logic              spi_mosi;
    logic              spi_miso;

    int checks = 0;
    int failures = 0;

    logic [7:0] tbytes [256];
    logic [7:0] mlog   [256];
    logic [7:0] rlog   [256];
    logic [7:0] wbuf   [64];
    int tot_bits = 0;
    int bit_base = 0;
    int rd_cnt = 0;
    int cs_hi_run = 0;
    int hi_run = 0;
    int last_hi = 0;

    always #2 clk = ~clk;

    spi_regx_host #(.DIV_W(DIV_W), .POLL_W(POLL_W)) i_spi_regx_host (
        .clk(clk), .rst(rst), .cfg_half_div(cfg_half_div), .cfg_poll_max(cfg_poll_max),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    assign wr_data  = wbuf[wr_idx];
    assign spi_miso = tbytes[((tot_bits - bit_base) >> 3) & 255][7 - ((tot_bits - bit_base) & 7)];

    // target model: capture MOSI on rising serial clock
    always @(posedge spi_sclk) begin
        mlog[((tot_bits - bit_base) >> 3) & 255][7 - ((tot_bits - bit_base) & 7)] = spi_mosi;
        tot_bits = tot_bits + 1;
    end

    always @(posedge clk) begin
        if (rd_valid) begin
            rlog[rd_cnt & 255] = rd_data;
            rd_cnt = rd_cnt + 1;
        end
        cs_hi_run = spi_cs_n ? cs_hi_run + 1 : 0;
        if (spi_sclk) hi_run = hi_run + 1;
        else begin
            if (hi_run != 0) last_hi = hi_run;
            hi_run = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_cmd(input bit rd, input int len);
        logic [6:0] lm1;
        lm1 = 7'(len - 1);
        return {rd, 1'b0, lm1[5:0]};
    endfunction

    task automatic run_txn(input bit rd, input logic [23:0] addr, input int len,
                           input int nwait, input int div, input int pmax, input bit poke);
        bit timeout;
        int npoll, nbytes, rd_base, guard, cs_run, ebytes, bad, first_bad;
        bit err_seen;
        timeout = (nwait > pmax);
        npoll   = timeout ? pmax : nwait;
        for (int i = 0; i < 256; i++) tbytes[i] = 8'($urandom);
        for (int i = 3; i < 3 + nwait && i < 256; i++) tbytes[i][0] = 1'b0;
        if (3 + nwait < 256) tbytes[3 + nwait][0] = 1'b1;
        for (int k = 0; k < len && 4 + nwait + k < 256; k++) tbytes[4 + nwait + k][0] = k[0];
        for (int k = 0; k < 64; k++) wbuf[k] = 8'($urandom);
        @(negedge clk);
        cfg_half_div = DIV_W'(div);
        cfg_poll_max = POLL_W'(pmax);
        bit_base = tot_bits;
        rd_base  = rd_cnt;
        cmd_valid = 1'b1;
        cmd_read  = rd;
        cmd_addr  = addr;
        cmd_len   = 7'(len);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            check(cmd_ready == 1'b0, "R10 ready low while busy", cmd_ready, 0);
            cmd_valid = 1'b1;
            cmd_read  = ~rd;
            cmd_addr  = ~addr;
            cmd_len   = 7'd3;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        guard = 0;
        while (!done && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1, "R8 done reached", done, 1);
        err_seen = err;
        cs_run   = cs_hi_run;
        nbytes   = (tot_bits - bit_base) / 8;
        ebytes   = timeout ? 4 + pmax : 4 + nwait + len;
        check(((tot_bits - bit_base) % 8) == 0, "R2 whole bytes", (tot_bits - bit_base) % 8, 0);
        check(nbytes == ebytes, rd ? "R3/R4/R5 frame length" : "R3/R4 frame length", nbytes, ebytes);
        check(mlog[0] == exp_cmd(rd, len), "R1 command byte", mlog[0], exp_cmd(rd, len));
        check(mlog[1] == addr[23:16], "R1 address high", mlog[1], addr[23:16]);
        check(mlog[2] == addr[15:8], "R1 address mid", mlog[2], addr[15:8]);
        check(mlog[3] == addr[7:0], "R1 address low", mlog[3], addr[7:0]);
        bad = 0; first_bad = 0;
        for (int i = 4; i < 4 + npoll; i++) if (mlog[i] != 8'h00) begin bad++; first_bad = mlog[i]; end
        check(bad == 0, "R4 filler bytes zero", first_bad, 0);
        check(err_seen == timeout, "R9 error flag", err_seen, timeout);
        check(cs_run >= 2 * (div + 1), "R8 release time", cs_run, 2 * (div + 1));
        check(last_hi == div + 1, "R2 high phase length", last_hi, div + 1);
        if (!timeout) begin
            bad = 0; first_bad = 0;
            for (int k = 0; k < len; k++) begin
                if (rd) begin
                    if (mlog[4 + nwait + k] != 8'h00) begin bad++; first_bad = mlog[4 + nwait + k]; end
                end else begin
                    if (mlog[4 + nwait + k] != wbuf[k]) begin bad++; first_bad = k; end
                end
            end
            check(bad == 0, rd ? "R7 read filler on MOSI" : "R6 write payload", first_bad, 0);
        end
        check(rd_cnt - rd_base == ((rd && !timeout) ? len : 0), "R7 read strobe count",
              rd_cnt - rd_base, (rd && !timeout) ? len : 0);
        if (rd && !timeout) begin
            bad = 0; first_bad = 0;
            for (int k = 0; k < len; k++)
                if (rlog[(rd_base + k) & 255] != tbytes[4 + nwait + k]) begin bad++; first_bad = k; end
            check(bad == 0, "R7 read data", first_bad, 0);
        end
        if (poke) begin
            repeat (12) @(negedge clk);
            check(spi_cs_n == 1'b1 && cmd_ready == 1'b1, "R10 mid-transfer command ignored", spi_cs_n, 1);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0217));
        for (int i = 0; i < 64; i++) wbuf[i] = '0;
        for (int i = 0; i < 256; i++) tbytes[i] = '0;
        repeat (4) @(negedge clk);
        check(spi_cs_n == 1'b1, "R11 cs after reset", spi_cs_n, 1);
        check(spi_sclk == 1'b0, "R11 sclk after reset", spi_sclk, 0);
        check(cmd_ready == 1'b1, "R11 ready after reset", cmd_ready, 1);
        check(done == 1'b0 && err == 1'b0 && rd_valid == 1'b0, "R11 status after reset", done, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // directed corner cases
        run_txn(1'b0, 24'hAABBCC, 4, 0, 1, 4, 1'b0);   // R3 write, ready at once
        run_txn(1'b1, 24'h123456, 4, 3, 0, 5, 1'b0);   // R4 read, three waits
        run_txn(1'b1, 24'h00FF01, 1, 0, 2, 2, 1'b0);   // shortest read
        run_txn(1'b0, 24'hFEDCBA, 64, 1, 0, 2, 1'b0);  // longest write
        run_txn(1'b1, 24'h0A0B0C, 64, 0, 0, 1, 1'b0);  // R5 longest read
        run_txn(1'b1, 24'h314159, 5, 4, 1, 4, 1'b0);   // R9 wait equals limit: ok
        run_txn(1'b0, 24'h271828, 5, 5, 1, 4, 1'b0);   // R9 limit plus one: error
        run_txn(1'b1, 24'h000001, 3, 1, 0, 0, 1'b0);   // R9 no polling allowed
        run_txn(1'b0, 24'h800000, 2, 0, 3, 0, 1'b0);   // ready with zero limit
        run_txn(1'b0, 24'h55AA55, 6, 2, 1, 6, 1'b1);   // R10 command while busy
        // constrained random
        for (int t = 0; t < 24; t++) begin
            int pm, nw;
            pm = $urandom_range(6, 0);
            nw = $urandom_range(pm + 1, 0);
            run_txn(1'($urandom), 24'($urandom), $urandom_range(16, 1), nw,
                    $urandom_range(2, 0), pm, 1'b0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule